// File: doc/BRIEF.md
# I2S Transmit Serializer with Word-Select Generator

This block turns a stream of audio sample words into the serial data line of an I2S transmitter. Samples arrive on a valid/ready handshake, are held in a one-word staging register and are shifted out MSB first. The first bit of each slot goes out one bit clock after the word-select change that opens the slot. Word select low marks the left slot. As bit-clock master, the block divides its system clock into a bit strobe and runs a programmable word-select counter. As slave, it samples an external word select on an external bit strobe.

A 16-bit control word sets the slot half period, the sample width, mono or stereo, stop, mute and the role. The same write can also fire a one-shot channel clear. Stereo samples pair strictly as left then right. Mono repeats one sample in both slots. Mute and stop replace the slot contents with zeros. The difference is that mute still consumes samples, while stop refuses them. The clock for the converter, the sample FIFO and bus decode live outside this block.

Top module: `i2s_tx_ser`

## Requirements
- R1: After reset the control word holds slave role, mute on, stop off, stereo, width code 1 and half period 31. In that state no bit strobe is generated, serial data stays 0, and word select follows the external one.
- R2: In master role the bit strobe `bit_en_o` pulses once every BCLK_DIV clocks, and `ws_o` toggles every (half+1) bit strobes. Here half is the 9-bit field in bits [8:0] of the control word.
- R3: Word select changes only on a bit strobe. The MSB of a slot appears on `sd_o` one bit strobe after the `ws_o` change that opens the slot, and the remaining bits follow MSB first.
- R4: Control bits [10:9] set the sample width: 0 means 8 bits from sample[7:0], 1 means 16 bits from sample[15:0], and 2 or 3 mean 32 bits. Slot bits after the sample's LSB are 0, and a slot shorter than the sample truncates it.
- R5: With bit 11 (mono) clear, accepted samples alternate between slots: the left slot (ws low) takes a sample, then the following right slot takes the next one. A right slot takes a sample only if the left slot of the same frame took one; otherwise it sends zeros.
- R6: With mono set, a sample taken in a left slot is also sent in the following right slot, and the right slot consumes nothing.
- R7: With bit 13 (mute) set, every slot sends zeros while samples are still accepted and consumed at the normal pace.
- R8: With bit 12 (stop) set, `smp_ready` is low and every slot sends zeros. A sample offered during stop is accepted once stop clears, and it goes to the next left slot.
- R9: With bit 14 set (slave), the block samples `ext_ws` on each `ext_bit_en`. It starts the new slot on the strobe after the one that saw the edge. The slot length follows the external word select, and the half field is ignored.
- R10: Writing the control word with bit 15 set clears the channel on the second clock after the write. From that point `sd_o` and `ws_o` are 0, the partly sent sample is dropped, and no right-slot partner is sent for it.
- R11: `smp_ready` may be high in the same cycle that the held sample leaves for a slot, so the staging register refills without losing a slot. No accepted sample is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: [8:0] half, [10:9] width, [11] mono, [12] stop, [13] mute, [14] slave, [15] channel clear |
| smp_data | input | 32 | Sample word |
| smp_valid | input | 1 | Sample word is valid |
| smp_ready | output | 1 | Block accepts the sample word this cycle |
| ext_bit_en | input | 1 | External bit strobe, used in slave role |
| ext_ws | input | 1 | External word select, used in slave role |
| bit_en_o | output | 1 | Generated bit strobe, master role only |
| ws_o | output | 1 | Word select for the bit currently on the line |
| sd_o | output | 1 | Serial data |

## Verification
Two functions can fall in the same cycle: the staging register accepting a new sample, and the held sample leaving for a slot. A channel clear can also land on a bit strobe. The bench provokes the first collision by holding valid high with the next sample while the previous one waits, so each refill happens exactly on a slot load. A scoreboard rebuilds every nonzero slot from `ws_o` and `sd_o` and judges the result by matching channel and content in order. A clear is issued while a sample is mid-slot. The lines are then checked two clocks later, and the channel is watched for a stray partner slot.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int SMP_W  = 32;
  localparam int HALF_W = 9;
  localparam int CFG_W  = 16;

  // control word bit positions
  localparam int B_HALF  = 0;
  localparam int B_WID   = 9;
  localparam int B_MONO  = 11;
  localparam int B_STOP  = 12;
  localparam int B_MUTE  = 13;
  localparam int B_SLAVE = 14;
  localparam int B_CLR   = 15;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_2X = 2'd2,
    WID_32 = 2'd3
  } wid_e;

  typedef struct packed {
    logic              slave;
    logic              mute;
    logic              stop;
    logic              mono;
    wid_e              wid;
    logic [HALF_W-1:0] half;
  } cfg_t;

  localparam cfg_t CFG_RST = '{slave: 1'b1, mute: 1'b1, stop: 1'b0, mono: 1'b0,
                               wid: WID_16, half: HALF_W'(31)};

  // place the sample at the top of the slot word, zeros below its LSB
  function automatic logic [SMP_W-1:0] justify(input logic [SMP_W-1:0] d, input wid_e w);
    logic [SMP_W-1:0] r;
    case (w)
      WID_8:   r = {d[7:0], {(SMP_W-8){1'b0}}};
      WID_16:  r = {d[15:0], {(SMP_W-16){1'b0}}};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic             clr
);
  cfg_t cfg_q, cfg_d;
  logic clr_q, clr_d;

  always_comb begin
    cfg_d = cfg_q;
    clr_d = 1'b0;
    if (we) begin
      cfg_d.half  = wdata[B_HALF +: HALF_W];
      cfg_d.wid   = wid_e'(wdata[B_WID +: 2]);
      cfg_d.mono  = wdata[B_MONO];
      cfg_d.stop  = wdata[B_STOP];
      cfg_d.mute  = wdata[B_MUTE];
      cfg_d.slave = wdata[B_SLAVE];
      clr_d       = wdata[B_CLR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      clr_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      clr_q <= clr_d;
    end
  end

  assign cfg = cfg_q;
  assign clr = clr_q;
endmodule

// File: rtl/i2s_tx_wsgen.sv
module i2s_tx_wsgen
  import i2s_tx_pkg::*;
#(
  parameter int BCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              slave,
  input  logic [HALF_W-1:0] half,
  input  logic              ext_bit_en,
  input  logic              ext_ws,
  output logic              tick,
  output logic              bit_en_o,
  output logic              ws_o,
  output logic              load,
  output logic              chan
);
  localparam int DIV_W = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_DIV - 1);

  logic [DIV_W-1:0]  dcnt_q, dcnt_d;
  logic [HALF_W-1:0] hcnt_q, hcnt_d;
  logic              ws_q, ws_d;
  logic              pend_q, pend_d;
  logic              int_tick, wrap, ws_now;

  always_comb begin
    int_tick = (dcnt_q == DIV_LAST);
    dcnt_d   = int_tick ? '0 : dcnt_q + 1'b1;
    tick     = slave ? ext_bit_en : int_tick;
    wrap     = (hcnt_q >= half);
    ws_now   = slave ? ext_ws : (wrap ? ~ws_q : ws_q);
    hcnt_d   = hcnt_q;
    ws_d     = ws_q;
    pend_d   = pend_q;
    if (tick) begin
      hcnt_d = (slave || wrap) ? '0 : hcnt_q + 1'b1;
      ws_d   = ws_now;
      pend_d = ws_now ^ ws_q;
    end
    if (clr) begin
      dcnt_d = '0;
      hcnt_d = '0;
      ws_d   = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      hcnt_q <= '0;
      ws_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      hcnt_q <= hcnt_d;
      ws_q   <= ws_d;
      pend_q <= pend_d;
    end
  end

  assign bit_en_o = int_tick & ~slave;
  assign ws_o     = ws_q;
  assign load     = tick & pend_q & ~clr;
  assign chan     = ws_q;
endmodule

// File: rtl/i2s_tx_feed.sv
module i2s_tx_feed
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             chan,
  input  logic             mono,
  input  logic             stop,
  input  logic             mute,
  input  wid_e             wid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  output logic [SMP_W-1:0] word
);
  logic [SMP_W-1:0] hold_q, hold_d;
  logic [SMP_W-1:0] keep_q, keep_d;
  logic             hvld_q, hvld_d;
  logic             ltk_q, ltk_d;
  logic             take_l, take_r, take, acc;
  logic [SMP_W-1:0] raw;

  always_comb begin
    take_l    = load & ~chan & hvld_q & ~stop;
    take_r    = load & chan & ~mono & ltk_q & hvld_q & ~stop;
    take      = take_l | take_r;
    smp_ready = (~hvld_q | take) & ~stop & ~clr;
    acc       = smp_valid & smp_ready;

    hold_d = acc ? smp_data : hold_q;
    hvld_d = acc | (hvld_q & ~take);
    keep_d = take_l ? hold_q : keep_q;
    ltk_d  = ltk_q;
    if (load) ltk_d = chan ? 1'b0 : take_l;
    if (clr) begin
      hvld_d = 1'b0;
      ltk_d  = 1'b0;
      keep_d = '0;
    end

    if (!chan)     raw = take_l ? hold_q : '0;
    else if (mono) raw = ltk_q ? keep_q : '0;
    else           raw = take_r ? hold_q : '0;
    word = (mute | stop) ? '0 : justify(raw, wid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      keep_q <= '0;
      hvld_q <= 1'b0;
      ltk_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      keep_q <= keep_d;
      hvld_q <= hvld_d;
      ltk_q  <= ltk_d;
    end
  end
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             load,
  input  logic [SMP_W-1:0] word,
  output logic             sd_o
);
  logic [SMP_W-1:0] sh_q, sh_d;
  logic             sd_q, sd_d;

  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    if (tick) begin
      if (load) begin
        sd_d = word[SMP_W-1];
        sh_d = {word[SMP_W-2:0], 1'b0};
      end else begin
        sd_d = sh_q[SMP_W-1];
        sh_d = {sh_q[SMP_W-2:0], 1'b0};
      end
    end
    if (clr) begin
      sh_d = '0;
      sd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
  import i2s_tx_pkg::*;
#(
  parameter int BCLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             ext_bit_en,
  input  logic             ext_ws,
  output logic             bit_en_o,
  output logic             ws_o,
  output logic             sd_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_s;
  cfg_t             cfg;
  logic             clr, tick, load, chan;
  logic             cfg_mute, cfg_stop, cfg_mono, cfg_slave;
  wid_e             cfg_wid;
  logic [SMP_W-1:0] word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign cfg_mute  = cfg.mute;
  assign cfg_stop  = cfg.stop;
  assign cfg_mono  = cfg.mono;
  assign cfg_slave = cfg.slave;
  assign cfg_wid   = cfg.wid;

  i2s_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg), .clr(clr)
  );

  i2s_tx_wsgen #(.BCLK_DIV(BCLK_DIV)) u_wsgen (
    .clk(clk), .rst_n(rst_s), .clr(clr), .slave(cfg_slave), .half(cfg.half),
    .ext_bit_en(ext_bit_en), .ext_ws(ext_ws), .tick(tick), .bit_en_o(bit_en_o),
    .ws_o(ws_o), .load(load), .chan(chan)
  );

  i2s_tx_feed u_feed (
    .clk(clk), .rst_n(rst_s), .clr(clr), .load(load), .chan(chan),
    .mono(cfg_mono), .stop(cfg_stop), .mute(cfg_mute), .wid(cfg_wid),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready), .word(word)
  );

  i2s_tx_shift u_shift (
    .clk(clk), .rst_n(rst_s), .clr(clr), .tick(tick), .load(load), .word(word), .sd_o(sd_o)
  );
endmodule

// File: rtl/i2s_tx_ser_chk.sv
module i2s_tx_ser_chk (
  input logic clk,
  input logic rst_s,
  input logic tick,
  input logic load,
  input logic clr,
  input logic cfg_mute,
  input logic cfg_stop,
  input logic smp_ready,
  input logic bit_en_o,
  input logic ws_o,
  input logic sd_o
);
  // R2: generated strobe never lasts two cycles
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_s)
    bit_en_o |=> !bit_en_o);

  // R3: word select moves only on a bit strobe
  a_r3_ws_on_tick: assert property (@(posedge clk) disable iff (!rst_s)
    (!tick && !clr) |=> $stable(ws_o));

  // R7: a slot started under mute begins with a zero
  a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (load && cfg_mute) |=> !sd_o);

  // R8: stop blocks the handshake
  a_r8_stop_blocks: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_stop |-> !smp_ready);

  // R10: a channel clear leaves both lines low
  a_r10_clr_idle: assert property (@(posedge clk) disable iff (!rst_s)
    clr |=> (!sd_o && !ws_o));
endmodule

bind i2s_tx_ser i2s_tx_ser_chk u_chk (
  .clk(clk), .rst_s(rst_s), .tick(tick), .load(load), .clr(clr),
  .cfg_mute(cfg_mute), .cfg_stop(cfg_stop), .smp_ready(smp_ready),
  .bit_en_o(bit_en_o), .ws_o(ws_o), .sd_o(sd_o)
);

// File: tb/i2s_tx_ser_test.sv
`timescale 1ns/1ps
module i2s_tx_ser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] smp_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic        ext_bit_en = 1'b0;
  logic        ext_ws = 1'b0;
  logic        bit_en_o, ws_o, sd_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ext_run = 1'b0;
  bit tb_slave = 1'b1;
  bit mon_off = 1'b0;
  bit lr = 1'b0;
  string mon_tag = "R3";
  logic exp_c[$];
  logic [31:0] exp_w[$];

  // monitor state
  logic m_prev = 1'b0;
  bit m_start = 1'b0;
  bit m_coll = 1'b0;
  logic m_chan = 1'b0;
  logic [31:0] m_acc = '0;
  int m_n = 0;
  int ones_cnt = 0;
  int tog_cnt = 0;

  i2s_tx_ser #(.BCLK_DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .ext_bit_en(ext_bit_en), .ext_ws(ext_ws), .bit_en_o(bit_en_o),
    .ws_o(ws_o), .sd_o(sd_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // external bit strobe and word select for slave role
  initial begin
    int sc = 0;
    int bc = 0;
    forever begin
      @(posedge clk);
      #1;
      if (ext_run) begin
        sc = (sc == 3) ? 0 : sc + 1;
        ext_bit_en = (sc == 3);
        if (sc == 3) begin
          bc++;
          if (bc == 24) begin
            bc = 0;
            ext_ws = ~ext_ws;
          end
        end
      end else begin
        ext_bit_en = 1'b0;
      end
    end
  end

  function automatic logic [31:0] just(input logic [31:0] d, input logic [1:0] w);
    if (w == 2'd0) return {d[7:0], 24'h0};
    if (w == 2'd1) return {d[15:0], 16'h0};
    return d;
  endfunction

  function automatic logic [15:0] mk(input logic [8:0] half, input logic [1:0] w, input bit mono,
                                     input bit stop, input bit mute, input bit slave, input bit clr);
    return {clr, slave, mute, stop, mono, w, half};
  endfunction

  task automatic finish_slot();
    logic [31:0] mask;
    logic ec;
    logic [31:0] ew;
    if (m_coll && m_acc != 0 && !mon_off) begin
      mask = (m_n >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> m_n);
      if (exp_w.size() == 0) begin
        chk(1'b0, {mon_tag, " unexpected slot"}, m_acc, 32'h0);
      end else begin
        ec = exp_c.pop_front();
        ew = exp_w.pop_front();
        chk(m_chan == ec, {mon_tag, " channel"}, {31'h0, m_chan}, {31'h0, ec});
        chk((m_acc & mask) == (ew & mask), {mon_tag, " slot data"}, m_acc & mask, ew & mask);
      end
    end
  endtask

  task automatic take_bit(input logic ws, input logic sd);
    if (m_start) begin
      finish_slot();
      m_chan = ws;
      m_acc = '0;
      m_n = 0;
      m_coll = 1'b1;
      m_start = 1'b0;
    end
    if (m_coll) begin
      if (m_n < 32) m_acc[31-m_n] = sd;
      m_n++;
    end
    if (sd) ones_cnt++;
    if (ws != m_prev) begin
      m_start = 1'b1;
      tog_cnt++;
    end
    m_prev = ws;
  endtask

  // monitor: one bit per strobe, read after the strobe's edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (tb_slave ? ext_bit_en : bit_en_o)) begin
        @(negedge clk);
        take_bit(ws_o, sd_o);
      end
    end
  end

  task automatic write_cfg(input logic [15:0] v);
    @(posedge clk);
    #1 cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic handshake(input string tag);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!smp_ready && t < 4000);
    @(posedge clk);
    #1 smp_valid = 1'b0;
    if (t >= 4000) chk(1'b0, {tag, " handshake"}, 32'h0, 32'h1);
  endtask

  task automatic send(input logic [31:0] d, input bit push, input logic [1:0] w,
                      input bit mono, input string tag);
    if (push) begin
      if (mono) begin
        exp_c.push_back(1'b0); exp_w.push_back(just(d, w));
        exp_c.push_back(1'b1); exp_w.push_back(just(d, w));
      end else begin
        exp_c.push_back(lr); exp_w.push_back(just(d, w));
        lr = ~lr;
      end
    end
    @(posedge clk);
    #1 smp_valid = 1'b1;
    smp_data = d;
    handshake(tag);
  endtask

  task automatic wait_empty(input string tag);
    int t = 0;
    while (exp_w.size() != 0 && t < 6000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_w.size() == 0, {tag, " scoreboard drained"}, exp_w.size(), 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int gap;
    int rdy_seen;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk(sd_o == 1'b0, "R1 sd after reset", {31'h0, sd_o}, 32'h0);
    chk(ws_o == 1'b0, "R1 ws after reset", {31'h0, ws_o}, 32'h0);
    chk(smp_ready == 1'b1, "R1 ready after reset", {31'h0, smp_ready}, 32'h1);
    gap = 0;
    repeat (20) begin @(negedge clk); if (bit_en_o) gap++; end
    chk(gap == 0, "R1 no strobe in slave default", gap, 32'h0);
    // R1 R9: default slave follows external ws, default mute zeros the data
    ext_run = 1'b1;
    ones_cnt = 0; tog_cnt = 0;
    send(32'hFFFF_FFFF, 1'b0, 2'd1, 1'b0, "R1");
    send(32'hFFFF_FFFF, 1'b0, 2'd1, 1'b0, "R1");
    idle(600);
    chk(ones_cnt == 0, "R1 muted by default", ones_cnt, 32'h0);
    chk(tog_cnt >= 4, "R1 ws follows external", tog_cnt, 32'h4);
    ext_run = 1'b0;
    idle(8);

    // R2: master timing
    tb_slave = 1'b0;
    write_cfg(mk(9'd31, 2'd3, 0, 0, 0, 0, 0));
    do @(negedge clk); while (!bit_en_o);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!bit_en_o);
    chk(gap == 4, "R2 strobe period", gap, 32'd4);
    begin
      logic w0;
      w0 = ws_o;
      do @(negedge clk); while (ws_o == w0);
      w0 = ws_o;
      gap = 0;
      do begin @(negedge clk); gap++; end while (ws_o == w0);
      chk(gap == 128, "R2 ws half period", gap, 32'd128);
    end

    // R3 R5 R11: stereo 32-bit, back-to-back samples refill on slot load
    mon_tag = "R3 R5 R11 stereo"; lr = 1'b0;
    send(32'hA1B2_C3D4, 1'b1, 2'd3, 1'b0, "R5");
    send(32'h1357_9BDF, 1'b1, 2'd3, 1'b0, "R5");
    send(32'hF00D_0001, 1'b1, 2'd3, 1'b0, "R11");
    send(32'h8000_0003, 1'b1, 2'd3, 1'b0, "R11");
    wait_empty("R5");
    idle(300);

    // R4: 8-bit samples in 32-bit slots, low bits padded with zeros
    write_cfg(mk(9'd31, 2'd0, 0, 0, 0, 0, 0));
    mon_tag = "R4 width8"; lr = 1'b0;
    send(32'h1234_5681, 1'b1, 2'd0, 1'b0, "R4");
    send(32'hFFFF_FF3C, 1'b1, 2'd0, 1'b0, "R4");
    wait_empty("R4");
    idle(300);

    // R4: 16-bit samples in 16-bit slots
    write_cfg(mk(9'd15, 2'd1, 0, 0, 0, 0, 0));
    mon_tag = "R4 width16"; lr = 1'b0;
    send(32'h1234_ABCD, 1'b1, 2'd1, 1'b0, "R4");
    send(32'h0000_8421, 1'b1, 2'd1, 1'b0, "R4");
    wait_empty("R4");
    idle(300);

    // R6: mono repeats the sample
    write_cfg(mk(9'd31, 2'd3, 1, 0, 0, 0, 0));
    mon_tag = "R6 mono";
    send(32'hCAFE_F00D, 1'b1, 2'd3, 1'b1, "R6");
    send(32'h0BAD_BEEF, 1'b1, 2'd3, 1'b1, "R6");
    wait_empty("R6");
    idle(300);

    // R7: mute consumes samples, sends zeros
    write_cfg(mk(9'd31, 2'd3, 0, 0, 1, 0, 0));
    ones_cnt = 0;
    send(32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0, "R7");
    send(32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0, "R7");
    chk(1'b1, "R7 muted samples accepted", 32'h1, 32'h1);
    idle(700);
    chk(ones_cnt == 0, "R7 muted line", ones_cnt, 32'h0);

    // R8: stop blocks intake, then releases to the next left slot
    write_cfg(mk(9'd31, 2'd3, 0, 1, 0, 0, 0));
    ones_cnt = 0; rdy_seen = 0;
    @(posedge clk);
    #1 smp_valid = 1'b1; smp_data = 32'h7E57_0001;
    repeat (400) begin @(negedge clk); if (smp_ready) rdy_seen++; end
    chk(rdy_seen == 0, "R8 ready held low", rdy_seen, 32'h0);
    chk(ones_cnt == 0, "R8 stopped line", ones_cnt, 32'h0);
    mon_tag = "R8 release"; lr = 1'b0;
    exp_c.push_back(1'b0); exp_w.push_back(32'h7E57_0001); lr = 1'b1;
    write_cfg(mk(9'd31, 2'd3, 0, 0, 0, 0, 0));
    handshake("R8");
    send(32'h7E57_0002, 1'b1, 2'd3, 1'b0, "R8");
    wait_empty("R8");
    idle(300);

    // R10: channel clear during a slot
    mon_off = 1'b1;
    ones_cnt = 0;
    send(32'hFFFF_0000, 1'b0, 2'd3, 1'b0, "R10");
    gap = 0;
    while (ones_cnt == 0 && gap < 2000) begin @(negedge clk); gap++; end
    write_cfg(mk(9'd31, 2'd3, 0, 0, 0, 0, 1));
    @(negedge clk);
    @(negedge clk);
    chk(sd_o == 1'b0, "R10 sd cleared", {31'h0, sd_o}, 32'h0);
    chk(ws_o == 1'b0, "R10 ws cleared", {31'h0, ws_o}, 32'h0);
    ones_cnt = 0;
    idle(400);
    chk(ones_cnt == 0, "R10 partial sample dropped", ones_cnt, 32'h0);
    mon_off = 1'b0;
    mon_tag = "R10 recovery"; lr = 1'b0;
    send(32'h5A5A_0F0F, 1'b1, 2'd3, 1'b0, "R10");
    send(32'h0F0F_5A5A, 1'b1, 2'd3, 1'b0, "R10");
    wait_empty("R10");
    idle(300);

    // R9: slave role, 24-bit slots from the external word select
    write_cfg(mk(9'd31, 2'd3, 0, 0, 0, 1, 0));
    tb_slave = 1'b1;
    ext_run = 1'b1;
    idle(40);
    mon_tag = "R9 slave"; lr = 1'b0;
    send(32'hDEAD_BEEF, 1'b1, 2'd3, 1'b0, "R9");
    send(32'h1122_3344, 1'b1, 2'd3, 1'b0, "R9");
    send(32'h9988_7766, 1'b1, 2'd3, 1'b0, "R9");
    send(32'h8001_0001, 1'b1, 2'd3, 1'b0, "R9");
    wait_empty("R9");
    idle(300);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule